// File: doc/BRIEF.md
# I2C Master Clock Generator with Slave Stretch Support

This block produces the serial clock for an I2C master. A down-counter, loaded from a 7-bit reload input, times every low and every high phase of the clock. Counting advances once per machine cycle, which is one step every four system clocks. The block drives the line low through an open-drain style control (`scl_drive_low`). To produce a high level it only releases the line, which then floats high.

After each release the block watches the real line level, which reaches it through a two-flop synchroniser. A slave may hold the line low to stretch the clock. While it does, the counter is frozen. The counter is reloaded only on the first machine-cycle tick that sees the line high. Stretching therefore adds to the period and never shortens the high phase.

A byte engine uses two single-cycle strobes. One marks each observed rising edge and the other each driven falling edge, so the engine knows when to sample or change SDA. Deasserting the enable stops the clock and leaves the line released.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is active, and from the first clock edge after `enable` is seen low, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are all 0.
- R2: On the first clock edge that sees `enable` high after being idle, the block drives the line low and pulses `scl_fall_stb` in the same cycle.
- R3: A low phase lasts exactly 4*(reload+1) system clocks from its `scl_fall_stb` to the cycle in which `scl_drive_low` returns to 0. Reload 0 gives 4 clocks.
- R4: After a release, the phase counter holds its value while the synchronised line is low. `scl_rise_stb` pulses only on a machine-cycle tick at which the line, delayed by two synchroniser flops, reads high, and only while the line is released.
- R5: A high phase lasts exactly 4*(reload+1) clocks from `scl_rise_stb` to the next `scl_fall_stb`, however long a slave stretched the preceding low. At that point `scl_drive_low` is 1 again.
- R6: Each strobe is high for exactly one cycle, and the two strobes are never high together.
- R7: The reload input is captured at the start of each phase. A change during a phase affects only later phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when high |
| reload | input | 7 | Phase length in machine cycles, minus one |
| scl_in | input | 1 | Level sampled from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise_stb | output | 1 | One-cycle pulse at an observed SCL rising edge |
| scl_fall_stb | output | 1 | One-cycle pulse at a driven SCL falling edge |

## Verification
The reference model tracks phase, remaining count, tick position and the synchroniser. Any wrong internal state therefore shows within one machine cycle (four clocks) as a mismatch on `scl_drive_low` or a strobe. A counter that keeps running during a stretch shows as a high phase shorter than 4*(reload+1) clocks, measured from the rise strobe. A missing synchroniser stage moves the rise strobe one tick early. A reload captured at the wrong time changes the length of the phase that follows the reload change.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_WAIT = 2'd2,
      PH_HIGH = 2'd3
   } phase_e;
endpackage

// File: rtl/scl_line_sync.sv
`timescale 1ns/1ps
module scl_line_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   initial assert (STAGES >= 2) else $error("scl_line_sync: STAGES must be at least 2");

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= RESET_VAL;
            else        sh[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= RESET_VAL;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/scl_tick_div.sv
`timescale 1ns/1ps
module scl_tick_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   initial assert (DIV >= 1) else $error("scl_tick_div: DIV must be at least 1");

   if (DIV == 1) begin : g_pass
      assign tick = run;
   end else begin : g_cnt
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] pos;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           pos <= '0;
         else if (!run)        pos <= '0;
         else if (pos == LAST) pos <= '0;
         else                  pos <= pos + 1'b1;
      end

      assign tick = run && (pos == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick); // R3
   end
endmodule

// File: rtl/scl_baud_cnt.sv
`timescale 1ns/1ps
module scl_baud_cnt #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic         dec,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         zero
);
   initial assert (W >= 1) else $error("scl_baud_cnt: W must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !clr && !load) |-> (cnt != '0)); // R3
endmodule

// File: rtl/scl_phase_ctrl.sv
`timescale 1ns/1ps
module scl_phase_ctrl
   import scl_gen_pkg::*;
#(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         scl_hi,
   input  logic         cnt_zero,
   input  logic [W-1:0] cnt,
   output logic         run,
   output logic         load,
   output logic         dec,
   output logic         drv_q,
   output logic         rise_q,
   output logic         fall_q
);
   phase_e st_q, st_d;
   logic   rise_d, fall_d;

   always_comb begin
      st_d   = st_q;
      load   = 1'b0;
      dec    = 1'b0;
      rise_d = 1'b0;
      fall_d = 1'b0;
      if (!en) begin
         st_d = PH_IDLE;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               st_d   = PH_LOW;
               load   = 1'b1;
               fall_d = 1'b1;
            end
            PH_LOW: if (tick) begin
               if (cnt_zero) st_d = PH_WAIT;
               else          dec  = 1'b1;
            end
            PH_WAIT: if (tick && scl_hi) begin
               st_d   = PH_HIGH;
               load   = 1'b1;
               rise_d = 1'b1;
            end
            PH_HIGH: if (tick) begin
               if (cnt_zero) begin
                  st_d   = PH_LOW;
                  load   = 1'b1;
                  fall_d = 1'b1;
               end else begin
                  dec = 1'b1;
               end
            end
            default: st_d = PH_IDLE;
         endcase
      end
   end

   assign run = en && (st_q != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         drv_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         drv_q  <= (st_d == PH_LOW);
         rise_q <= rise_d;
         fall_q <= fall_d;
      end
   end

   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_q && fall_q)); // R6
   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |=> !rise_q); // R6
   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |=> !fall_q); // R6
   AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> !drv_q); // R4
   AST_RISE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> $past(scl_hi)); // R4
   AST_FALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |-> drv_q); // R5
   AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!drv_q && !rise_q && !fall_q)); // R1
   AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && st_q == PH_WAIT && !(tick && scl_hi)) |=> $stable(cnt)); // R4
endmodule

// File: rtl/scl_clock_gen.sv
`timescale 1ns/1ps
module scl_clock_gen #(
   parameter int RELOAD_W    = 7,
   parameter int TICK_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [RELOAD_W-1:0] reload,
   input  logic                scl_in,
   output logic                scl_drive_low,
   output logic                scl_rise_stb,
   output logic                scl_fall_stb
);
   logic                scl_hi;
   logic                tick;
   logic                run;
   logic                load;
   logic                dec;
   logic                cnt_zero;
   logic [RELOAD_W-1:0] cnt;

   initial assert (RELOAD_W >= 1 && TICK_DIV >= 1 && SYNC_STAGES >= 2)
      else $error("scl_clock_gen: illegal parameter set");

   scl_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_hi)
   );

   scl_tick_div #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   scl_baud_cnt #(.W(RELOAD_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!enable),
      .load     (load),
      .dec      (dec),
      .load_val (reload),
      .cnt      (cnt),
      .zero     (cnt_zero)
   );

   scl_phase_ctrl #(.W(RELOAD_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .tick     (tick),
      .scl_hi   (scl_hi),
      .cnt_zero (cnt_zero),
      .cnt      (cnt),
      .run      (run),
      .load     (load),
      .dec      (dec),
      .drv_q    (scl_drive_low),
      .rise_q   (scl_rise_stb),
      .fall_q   (scl_fall_stb)
   );
endmodule

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [6:0] reload = 7'd3;
   logic       slave_hold = 1'b0;
   logic       scl_in;
   logic       scl_drive_low, scl_rise_stb, scl_fall_stb;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   assign scl_in = !(scl_drive_low || slave_hold);

   scl_clock_gen u_scl_clock_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .reload        (reload),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .scl_rise_stb  (scl_rise_stb),
      .scl_fall_stb  (scl_fall_stb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 low, 2 waiting for line, 3 high
   int m_ph, m_rem, m_div, m_nph, m_lo_rel, m_hi_rel;
   bit m_s1, m_s2, m_tk;
   bit e_drv, e_rise, e_fall;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_rem = 0; m_div = 0; m_s1 = 1; m_s2 = 1;
         e_drv = 0; e_rise = 0; e_fall = 0; m_lo_rel = 0; m_hi_rel = 0;
      end else begin
         m_tk = enable && (m_ph != 0) && (m_div == 3);
         m_nph = m_ph; e_rise = 0; e_fall = 0;
         if (!enable) begin
            m_nph = 0;
         end else if (m_ph == 0) begin
            m_nph = 1; m_rem = int'(reload); m_lo_rel = int'(reload); e_fall = 1;
         end else if (m_tk) begin
            if (m_ph == 1) begin
               if (m_rem == 0) m_nph = 2; else m_rem--;
            end else if (m_ph == 2) begin
               if (m_s2) begin
                  m_nph = 3; m_rem = int'(reload); m_hi_rel = int'(reload); e_rise = 1;
               end
            end else begin
               if (m_rem == 0) begin
                  m_nph = 1; m_rem = int'(reload); m_lo_rel = int'(reload); e_fall = 1;
               end else m_rem--;
            end
         end
         m_div = (!enable || m_ph == 0) ? 0 : (m_div + 1) % 4;
         m_s2 = m_s1; m_s1 = scl_in;
         m_ph = m_nph;
         e_drv = (m_nph == 1);
      end
   end

   // Per-cycle comparison, phase length measurement and slave stretching
   int cyc = 0, fall_cyc = 0, rise_cyc = 0, hi_run = 0, hold_cnt = 0;
   int stretch_len = 0;
   bit fall_v = 0, rise_v = 0, prev_drv = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(scl_drive_low == e_drv, "R3/R5 drive", int'(scl_drive_low), int'(e_drv));
         chk(scl_rise_stb == e_rise, "R4 rise strobe", int'(scl_rise_stb), int'(e_rise));
         chk(scl_fall_stb == e_fall, "R5 fall strobe", int'(scl_fall_stb), int'(e_fall));
         chk(!(scl_rise_stb && scl_fall_stb), "R6 exclusive", 1, 0);
         if (scl_in) hi_run++; else hi_run = 0;
         if (!enable) begin
            fall_v = 0; rise_v = 0;
         end else begin
            if (scl_fall_stb) begin
               if (rise_v)
                  chk(cyc - rise_cyc == 4 * (m_hi_rel + 1), "R5 high length",
                      cyc - rise_cyc, 4 * (m_hi_rel + 1));
               fall_cyc = cyc; fall_v = 1; rise_v = 0;
               if (stretch_len > 0) begin
                  hold_cnt = 4 * (m_lo_rel + 1) + stretch_len;
                  slave_hold = 1'b1;
               end
            end
            if (prev_drv && !scl_drive_low && fall_v)
               chk(cyc - fall_cyc == 4 * (m_lo_rel + 1), "R3 low length",
                   cyc - fall_cyc, 4 * (m_lo_rel + 1));
            if (scl_rise_stb) begin
               chk(hi_run >= 3, "R4 line high before rise", hi_run, 3);
               rise_cyc = cyc; rise_v = 1;
            end
         end
         if (hold_cnt > 0) begin
            hold_cnt--;
            if (hold_cnt == 0) slave_hold = 1'b0;
         end
         prev_drv = scl_drive_low;
      end
   end

   task automatic run_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cnt;
      repeat (4) @(negedge clk);
      chk(scl_drive_low == 0 && scl_rise_stb == 0 && scl_fall_stb == 0,
          "R1 reset state", int'(scl_drive_low), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2: start from idle
      @(posedge clk); #1 reload = 7'd3; enable = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(scl_drive_low == 1 && scl_fall_stb == 1, "R2 start drives low",
          int'(scl_drive_low), 1);
      run_cycles(200);

      // R7: reload changed inside a low phase applies only later
      do @(negedge clk); while (!scl_fall_stb);
      @(posedge clk); #1 reload = 7'd9;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (scl_drive_low);
      chk(cnt == 16, "R7 reload captured at phase start", cnt, 16);
      run_cycles(300);

      // R3/R5 shortest phase
      @(posedge clk); #1 reload = 7'd0;
      run_cycles(150);

      // R4/R5 stretched lows
      @(posedge clk); #1 reload = 7'd2; stretch_len = 10;
      run_cycles(300);
      @(posedge clk); #1 stretch_len = 37;
      run_cycles(400);
      @(posedge clk); #1 reload = 7'd0; stretch_len = 5;
      run_cycles(200);
      @(posedge clk); #1 stretch_len = 0;
      run_cycles(50);

      // long phases
      @(posedge clk); #1 reload = 7'd127;
      run_cycles(2200);

      // R1: disable mid-phase
      @(posedge clk); #1 enable = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(scl_drive_low == 0 && scl_rise_stb == 0 && scl_fall_stb == 0,
          "R1 disable releases line", int'(scl_drive_low), 0);
      run_cycles(20);
      chk(scl_drive_low == 0, "R1 stays released", int'(scl_drive_low), 0);

      // restart
      @(posedge clk); #1 reload = 7'd5; enable = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(scl_fall_stb == 1, "R2 restart strobe", int'(scl_fall_stb), 1);
      run_cycles(300);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule